// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block takes level-sensitive interrupt requests from a set of sources organised into groups of eight members and reports the winning request on two output lines, one low-priority and one high-priority. Each group's ordering is set by a priority word of eight ordered slots. Every slot holds a 3-bit member code, so software chooses which member sits in which rank. The first two slots of each group can be sent to the high output instead of the low one.

A control register names one source that overrides all slot ordering and chooses which of the two outputs it drives. A per-source enable word gates the inputs. The block recomputes two vector registers on every clock, each holding the winning source number for its output. An output line is raised whenever its vector is nonzero, so a handler reads the vector to find out which source to service. All state is reached through a plain 32-bit word-addressed read/write port.

Top module: `grp_irq_ctrl`

## Requirements
- R1: Reset clears the enable word, the control register and the routing register, and zeroes both vectors. It also loads every group priority word with the identity order, in which slot p holds code p-1, giving the word 32'h05003977.
- R2: Source n (numbered from 1) is considered only while enable bit n-1 is set and its input bit n-1 is high. With its enable bit clear, a source never appears in a vector.
- R3: Vector registers report the source number in bits 31:26 and read zero in all other bits. The number is 8*g + code + 1 for member code of group g, and 0 means nothing is pending. A vector reflects the inputs one clock edge after they are applied.
- R4: The low output line is high exactly when the low vector is nonzero, and the same holds for the high line and the high vector.
- R5: In a group priority word, slot p sits at bits [34-3p:32-3p] for p=1..3 and at bits [26-3p:24-3p] for p=4..8. The 3-bit value in a slot selects group member 0..7.
- R6: Within a group, the pending member in the lowest-numbered slot wins. A member whose code is held by no slot is never reported.
- R7: Groups are searched in ascending order, so any pending slot in group g beats every slot in group g+1.
- R8: Control bits 5:0 name an override source and bit 8 picks its output (1 = high, 0 = low). When that source is nonzero, no greater than the source count, enabled and active, it wins its chosen output over all slot results. The other output is unaffected. Control reads back only bits 8 and 5:0.
- R9: The routing word has a 2-bit field per slot for slots 1 and 2 of group g, placed at bit 4g + (2-p)*2. The value 2'b01 sends that slot to the high output, and any other value leaves it on the low output. The high vector searches only routed slots, and the low vector searches all the others.
- R10: The word map is 0 control, 1 enable, 2 routing, 3 low vector, 4 high vector, and 8+g group g priority. Writes to the vector words are ignored, and any other address reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | NUM_GROUPS*8 | Level request per source, bit n-1 for source n |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_low | output | 1 | Low request line |
| irq_high | output | 1 | High request line |

## Verification
The hardest situation to reach is one where the override source, a slot routed to the high line and an ordinary slot win are all live together. In that case each output must pick its own winner without disturbing the other. The stimulus first rewrites a group priority word so that some members become unreachable and the slot order no longer matches member order. It then programs routing fields, including a non-selecting field value, and finally aims the override at each output in turn while a lower-ranked source stays asserted, with one run that has the override source disabled.

// File: rtl/gpic_pkg.sv
package gpic_pkg;

    localparam int SLOTS   = 8;
    localparam int CODE_W  = 3;
    localparam int VEC_W   = 6;
    localparam int DATA_W  = 32;
    localparam int VEC_LSB = 26;

    localparam int A_CTRL  = 0;
    localparam int A_MASK  = 1;
    localparam int A_ROUTE = 2;
    localparam int A_VLO   = 3;
    localparam int A_VHI   = 4;
    localparam int A_PRIO  = 8;

    localparam logic [1:0] ROUTE_HIGH = 2'b01;

    typedef struct packed {
        logic              hit;
        logic [CODE_W-1:0] code;
    } slot_pick_t;

    typedef struct packed {
        logic             hp_high;
        logic [VEC_W-1:0] hp_src;
    } ctrl_t;

    function automatic int slot_lsb(input int p);
        return (p <= 3) ? (32 - 3 * p) : (24 - 3 * p);
    endfunction

    function automatic logic [DATA_W-1:0] ident_prio();
        logic [DATA_W-1:0] w;
        w = '0;
        for (int p = 1; p <= SLOTS; p++) begin
            w[slot_lsb(p) +: CODE_W] = CODE_W'(p - 1);
        end
        return w;
    endfunction

endpackage

// File: rtl/gpic_regs.sv
module gpic_regs
    import gpic_pkg::*;
#(
    parameter int NUM_GROUPS = 4,
    parameter int ADDR_W     = 5
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               wr_en,
    input  logic [ADDR_W-1:0]                  addr,
    input  logic [DATA_W-1:0]                  wdata,
    input  logic [VEC_W-1:0]                   vec_lo,
    input  logic [VEC_W-1:0]                   vec_hi,
    output logic [DATA_W-1:0]                  rdata,
    output ctrl_t                              ctrl,
    output logic [NUM_GROUPS*SLOTS-1:0]        mask,
    output logic [NUM_GROUPS*4-1:0]            route,
    output logic [NUM_GROUPS-1:0][DATA_W-1:0]  prio
);
    localparam int NSRC    = NUM_GROUPS * SLOTS;
    localparam int ROUTE_W = NUM_GROUPS * 4;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '0;
            mask  <= '0;
            route <= '0;
            for (int g = 0; g < NUM_GROUPS; g++) prio[g] <= ident_prio();
        end else if (wr_en) begin
            if (addr == ADDR_W'(A_CTRL)) begin
                ctrl.hp_src  <= wdata[VEC_W-1:0];
                ctrl.hp_high <= wdata[8];
            end
            if (addr == ADDR_W'(A_MASK))  mask  <= wdata[NSRC-1:0];
            if (addr == ADDR_W'(A_ROUTE)) route <= wdata[ROUTE_W-1:0];
            for (int g = 0; g < NUM_GROUPS; g++) begin
                if (addr == ADDR_W'(A_PRIO + g)) prio[g] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(A_CTRL))  rdata = {23'b0, ctrl.hp_high, 2'b0, ctrl.hp_src};
        if (addr == ADDR_W'(A_MASK))  rdata = DATA_W'(mask);
        if (addr == ADDR_W'(A_ROUTE)) rdata = DATA_W'(route);
        if (addr == ADDR_W'(A_VLO))   rdata = {vec_lo, 26'b0};
        if (addr == ADDR_W'(A_VHI))   rdata = {vec_hi, 26'b0};
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (addr == ADDR_W'(A_PRIO + g)) rdata = prio[g];
        end
    end

endmodule

// File: rtl/gpic_group_scan.sv
module gpic_group_scan
    import gpic_pkg::*;
(
    input  logic [SLOTS-1:0]  pend,
    input  logic [DATA_W-1:0] prio,
    input  logic [3:0]        route,
    output slot_pick_t        lo_pick,
    output slot_pick_t        hi_pick
);
    logic s1_high, s2_high;
    assign s1_high = (route[3:2] == ROUTE_HIGH);
    assign s2_high = (route[1:0] == ROUTE_HIGH);

    always_comb begin
        logic [CODE_W-1:0] code;
        logic              to_high;
        lo_pick = '0;
        hi_pick = '0;
        // descending walk: the lowest slot found last takes the result
        for (int p = SLOTS; p >= 1; p--) begin
            code    = prio[slot_lsb(p) +: CODE_W];
            to_high = ((p == 1) && s1_high) || ((p == 2) && s2_high);
            if (pend[code]) begin
                if (to_high) hi_pick = '{hit: 1'b1, code: code};
                else         lo_pick = '{hit: 1'b1, code: code};
            end
        end
    end

endmodule

// File: rtl/gpic_arbiter.sv
module gpic_arbiter
    import gpic_pkg::*;
#(
    parameter int NUM_GROUPS = 4
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_GROUPS*SLOTS-1:0]       pend_m,
    input  slot_pick_t [NUM_GROUPS-1:0]       lo_pick,
    input  slot_pick_t [NUM_GROUPS-1:0]       hi_pick,
    input  ctrl_t                             ctrl,
    output logic [VEC_W-1:0]                  vec_lo,
    output logic [VEC_W-1:0]                  vec_hi
);
    localparam int NSRC = NUM_GROUPS * SLOTS;

    logic [VEC_W-1:0] nxt_lo, nxt_hi;
    logic [NSRC-1:0]  hp_shift;
    logic             hp_ok;

    assign hp_shift = pend_m >> (ctrl.hp_src - VEC_W'(1));
    assign hp_ok    = (ctrl.hp_src != '0) && (int'(ctrl.hp_src) <= NSRC) && hp_shift[0];

    always_comb begin
        nxt_lo = '0;
        nxt_hi = '0;
        for (int g = NUM_GROUPS - 1; g >= 0; g--) begin
            if (lo_pick[g].hit) nxt_lo = VEC_W'(g * SLOTS + int'(lo_pick[g].code) + 1);
            if (hi_pick[g].hit) nxt_hi = VEC_W'(g * SLOTS + int'(hi_pick[g].code) + 1);
        end
        if (hp_ok) begin
            if (ctrl.hp_high) nxt_hi = ctrl.hp_src;
            else              nxt_lo = ctrl.hp_src;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_lo <= '0;
            vec_hi <= '0;
        end else begin
            vec_lo <= nxt_lo;
            vec_hi <= nxt_hi;
        end
    end

    assert_lo_live_R2: assert property (@(posedge clk) disable iff (rst)
        (vec_lo != '0) |-> ((int'(vec_lo) <= NSRC) &&
                            (|(($past(pend_m) >> (vec_lo - VEC_W'(1))) & NSRC'(1)))));

    assert_hi_live_R2: assert property (@(posedge clk) disable iff (rst)
        (vec_hi != '0) |-> ((int'(vec_hi) <= NSRC) &&
                            (|(($past(pend_m) >> (vec_hi - VEC_W'(1))) & NSRC'(1)))));

    assert_idle_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (pend_m == '0) |=> (vec_lo == '0 && vec_hi == '0));

    assert_override_low_R8: assert property (@(posedge clk) disable iff (rst)
        (hp_ok && !ctrl.hp_high) |=> (vec_lo == $past(ctrl.hp_src)));

    assert_override_high_R8: assert property (@(posedge clk) disable iff (rst)
        (hp_ok && ctrl.hp_high) |=> (vec_hi == $past(ctrl.hp_src)));

endmodule

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl
    import gpic_pkg::*;
#(
    parameter int NUM_GROUPS = 4,
    parameter int ADDR_W     = 5
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_GROUPS*8-1:0]      irq_src,
    input  logic                         reg_wr_en,
    input  logic [ADDR_W-1:0]            reg_addr,
    input  logic [31:0]                  reg_wdata,
    output logic [31:0]                  reg_rdata,
    output logic                         irq_low,
    output logic                         irq_high
);
    localparam int NSRC = NUM_GROUPS * SLOTS;

    ctrl_t                            ctrl;
    logic [NSRC-1:0]                  mask;
    logic [NUM_GROUPS*4-1:0]          route;
    logic [NUM_GROUPS-1:0][DATA_W-1:0] prio;
    logic [NSRC-1:0]                  pend_m;
    slot_pick_t [NUM_GROUPS-1:0]      lo_pick, hi_pick;
    logic [VEC_W-1:0]                 vec_lo, vec_hi;

    assign pend_m = irq_src & mask;

    gpic_regs #(.NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata),
        .vec_lo(vec_lo), .vec_hi(vec_hi), .rdata(reg_rdata),
        .ctrl(ctrl), .mask(mask), .route(route), .prio(prio)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_scan
        gpic_group_scan u_scan (
            .pend(pend_m[g*SLOTS +: SLOTS]),
            .prio(prio[g]),
            .route(route[g*4 +: 4]),
            .lo_pick(lo_pick[g]),
            .hi_pick(hi_pick[g])
        );
    end

    gpic_arbiter #(.NUM_GROUPS(NUM_GROUPS)) u_arb (
        .clk(clk), .rst(rst), .pend_m(pend_m),
        .lo_pick(lo_pick), .hi_pick(hi_pick), .ctrl(ctrl),
        .vec_lo(vec_lo), .vec_hi(vec_hi)
    );

    assign irq_low  = (vec_lo != '0);
    assign irq_high = (vec_hi != '0);

endmodule

// File: tb/grp_irq_ctrl_test.sv
module grp_irq_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] irq_src = '0;
    logic        reg_wr_en = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_low, irq_high;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    grp_irq_ctrl uut (
        .clk(clk), .rst(rst), .irq_src(irq_src), .reg_wr_en(reg_wr_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_low(irq_low), .irq_high(irq_high)
    );

    typedef struct packed {
        logic [31:0] mask;
        logic [31:0] src;
        logic [5:0]  lo;
        logic [5:0]  hi;
    } vec_t;

    // identity priority order, default routing, no override
    localparam vec_t TBL [8] = '{
        '{32'hFFFF_FFFF, 32'h0000_0000, 6'd0,  6'd0},
        '{32'hFFFF_FFFF, 32'h0000_0001, 6'd1,  6'd0},
        '{32'hFFFF_FFFF, 32'h0000_0028, 6'd4,  6'd0},
        '{32'hFFFF_FFFF, 32'h0000_0204, 6'd3,  6'd0},
        '{32'hFFFF_FFFF, 32'h8000_0000, 6'd32, 6'd0},
        '{32'h0000_0000, 32'hFFFF_FFFF, 6'd0,  6'd0},
        '{32'hFFFF_0000, 32'hFFFF_FFFF, 6'd17, 6'd0},
        '{32'h0000_0080, 32'h0000_00FF, 6'd8,  6'd0}
    };

    function automatic logic [31:0] prio_word(input logic [2:0] c [8]);
        logic [31:0] w = '0;
        for (int p = 1; p <= 8; p++) begin
            if (p <= 3) w[32-3*p +: 3] = c[p-1];
            else        w[24-3*p +: 3] = c[p-1];
        end
        return w;
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 5'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 5'(a);
        #1 d = reg_rdata;
    endtask

    task automatic drive(input logic [31:0] s);
        @(negedge clk);
        irq_src = s;
        @(negedge clk);
    endtask

    task automatic chk_vec(input logic [5:0] lo, input logic [5:0] hi, input string req);
        logic [31:0] d;
        rd(3, d); check(d, {lo, 26'b0}, {req, " low vector R3"});
        rd(4, d); check(d, {hi, 26'b0}, {req, " high vector R3"});
        check(32'(irq_low),  32'(lo != 0), {req, " low line R4"});
        check(32'(irq_high), 32'(hi != 0), {req, " high line R4"});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [2:0]  codes [8];
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(1, d); check(d, 32'h0, "R1 enable word");
        rd(0, d); check(d, 32'h0, "R1 control");
        rd(2, d); check(d, 32'h0, "R1 routing");
        for (int p = 0; p < 8; p++) codes[p] = 3'(p);
        rd(8, d);  check(d, prio_word(codes), "R1 R5 group0 identity");
        rd(11, d); check(d, 32'h0500_3977, "R1 group3 identity");
        chk_vec(0, 0, "R1 after reset");

        // table walk: R2 R6 R7
        for (int i = 0; i < 8; i++) begin
            wr(1, TBL[i].mask);
            drive(TBL[i].src);
            chk_vec(TBL[i].lo, TBL[i].hi, $sformatf("table %0d R2 R6 R7", i));
        end

        // R3 one-edge latency
        wr(1, 32'hFFFF_FFFF);
        drive(32'h0);
        @(negedge clk);
        irq_src = 32'h0000_0100;
        #1 check(32'(irq_low), 32'h0, "R3 before edge");
        @(negedge clk);
        check(32'(irq_low), 32'h1, "R3 after edge");
        chk_vec(9, 0, "R3 latency");

        // R5 R6 custom slot order in group 1: slot1=6, slot2=1, rest=7
        codes[0] = 3'd6; codes[1] = 3'd1;
        for (int p = 2; p < 8; p++) codes[p] = 3'd7;
        wr(9, prio_word(codes));
        rd(9, d); check(d, 32'hC780_7FFF, "R5 prio readback");
        drive(32'h0000_4200);
        chk_vec(15, 0, "R5 R6 slot1 beats slot2");
        drive(32'h0000_0400);
        chk_vec(0, 0, "R6 unslotted member ignored");
        drive(32'h0000_8000);
        chk_vec(16, 0, "R6 late slot");
        for (int p = 0; p < 8; p++) codes[p] = 3'(p);
        wr(9, prio_word(codes));

        // R9 routing to high line
        wr(2, 32'h0000_0004);
        drive(32'h0000_0001);
        chk_vec(0, 1, "R9 group0 slot1 high");
        drive(32'h0000_0003);
        chk_vec(2, 1, "R9 split outputs");
        wr(2, 32'h0000_0014);
        drive(32'h0000_0300);
        chk_vec(9, 10, "R9 group1 slot2 high");
        wr(2, 32'h0000_000C);
        drive(32'h0000_0001);
        chk_vec(1, 0, "R9 value 11 stays low");
        wr(2, 32'h0);

        // R8 override
        wr(0, 32'h0000_0014);
        drive(32'h0008_0001);
        chk_vec(20, 0, "R8 override low");
        wr(0, 32'h0000_0114);
        drive(32'h0008_0001);
        chk_vec(1, 20, "R8 override high");
        wr(0, 32'h0000_0014);
        wr(1, 32'hFFF7_FFFF);
        drive(32'h0008_0001);
        chk_vec(1, 0, "R8 R2 override disabled");
        wr(1, 32'hFFFF_FFFF);

        // R10 register map
        wr(0, 32'hFFFF_FFFF);
        rd(0, d); check(d, 32'h0000_013F, "R10 R8 control readback");
        wr(0, 32'h0);
        drive(32'h0000_0004);
        wr(3, 32'hFFFF_FFFF);
        wr(4, 32'hFFFF_FFFF);
        chk_vec(3, 0, "R10 vector write ignored");
        rd(5, d); check(d, 32'h0, "R10 unmapped read");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule